// File: doc/BRIEF.md
# Daisy-Chainable Serial Frame Receiver

This block is the serial slave front end of a four-channel converter. A host frames each transfer by pulling an active-low select line low and then clocks exactly 24 data bits in, most significant bit first, sampling on the falling edge of the serial clock. When the select line returns high after a full 24-bit frame, the block raises a one-cycle strobe in the system-clock domain and presents the captured word to the register logic. A select pulse with fewer than 24 falling edges is dropped.

While a frame is open, the block drives its serial output with a word of its own, changing it on serial-clock rising edges so that a downstream device can sample it on the next falling edge. Normally that word is the one captured in the previous complete frame, so several devices can be chained by wiring each output to the next input. A frame whose top four bits hold the readback code makes the following frame shift out the parallel word the register bank offers on `rb_word` instead. The serial lines are brought into the system clock through two-stage synchronizers, and every edge is found and acted on in that domain.

Top module: `dspi_frame_rx`

## Requirements
- R1: A complete frame is captured with its first serial bit at bit 23 of `word_out` and its last (24th) bit at bit 0.
- R2: Data is sampled only on serial-clock falling edges while the select line is low; the level of `ser_in` around rising edges has no effect on the captured word.
- R3: When the select line rises after at least 24 falling edges, `word_valid` is high for exactly one system clock and `word_out` takes the new word in that same cycle; `word_out` holds its value at all other times.
- R4: Falling edges beyond the 24th in a frame are ignored: the captured word holds the first 24 bits.
- R5: A frame ended with fewer than 24 falling edges is discarded: no strobe, `word_out` unchanged, and the chaining word and readback request both stay as the last complete frame left them.
- R6: `ser_out_en` is high only while the select line is low; when it is low the pad is to be released to high impedance, and `word_valid` is never high while it is high.
- R7: During a frame, `ser_out` presents the word of the previous complete frame (all zeros after reset), bit 23 from the frame start, moving to the next bit on each serial-clock rising edge that follows a falling edge of that frame, and 0 after bit 0.
- R8: When the previous complete frame had bits 23:20 equal to 4'b1001, the frame shifts out the value of `rb_word` present when the frame starts, in place of the previous word; any other value in bits 23:20 keeps the daisy-chain behaviour.
- R9: Every output is registered and responds on the third rising edge of `clk` after the serial-line transition that causes it.
- R10: After reset `word_valid`, `word_out`, `ser_out` and `ser_out_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_in | input | 1 | Serial data in |
| rb_word | input | 24 | Register contents offered for readback |
| ser_out | output | 1 | Serial data out |
| ser_out_en | output | 1 | Output drive enable for the serial data pad |
| word_valid | output | 1 | One-cycle strobe for a completed frame |
| word_out | output | 24 | Last completed frame |

## Verification
The properties assume that the host holds each serial level for at least three system clocks, so the synchronizers never drop or merge an edge, and that a select transition never falls in the same system clock as a serial-clock edge. They also assume `ser_in` is steady for those clocks around each falling edge. The stimulus meets this by holding every serial half-period for four system clocks and by putting four-clock gaps between the select edges and the first and last serial-clock edges. To show that rising edges are ignored, the data line is flipped at each rising edge.

// File: rtl/dspi_frx_pkg.sv
package dspi_frx_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_ev_t;

   function automatic edge_ev_t edge_of(input logic now_lvl, input logic old_lvl);
      edge_ev_t e;
      e.rise = now_lvl & ~old_lvl;
      e.fall = ~now_lvl & old_lvl;
      return e;
   endfunction

endpackage

// File: rtl/dspi_frx_sync.sv
module dspi_frx_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dspi_frx_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dspi_frx_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{IDLE}};
      end else begin
         pipe <= {pipe[STAGES-2:0], d};
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/dspi_frx_edge.sv
module dspi_frx_edge
   import dspi_frx_pkg::*;
#(
   parameter int           W      = 1,
   parameter int           STAGES = 2,
   parameter logic [W-1:0] IDLE   = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        d,
   output edge_ev_t [W-1:0]    ev
);

   logic [W-1:0] lvl;
   logic [W-1:0] prv;

   dspi_frx_sync #(
      .W      (W),
      .STAGES (STAGES),
      .IDLE   (IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (d),
      .q     (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prv <= IDLE;
      end else begin
         prv <= lvl;
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_lane
      assign ev[b] = edge_of(lvl[b], prv[b]);
   end

endmodule

// File: rtl/dspi_frx_rx.sv
module dspi_frx_rx #(
   parameter int                 FRAME_W   = 24,
   parameter int                 CMD_W     = 4,
   parameter logic [CMD_W-1:0]   RB_CODE   = 4'b1001,
   parameter bit                 RB_ENABLE = 1'b1,
   localparam int                CNT_W     = $clog2(FRAME_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_open,
   input  logic                sel_close,
   input  logic                sclk_fall,
   input  logic                din,
   output logic                in_frame,
   output logic [CNT_W-1:0]    bit_cnt,
   output logic                word_valid,
   output logic [FRAME_W-1:0]  word_out,
   output logic                rb_armed
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   if (CMD_W >= FRAME_W) begin : g_bad_cmd
      $error("dspi_frx_rx: CMD_W must be narrower than FRAME_W");
   end

   logic [FRAME_W-1:0] shreg;
   logic               cmd_hit;
   logic               cnt_full;

   if (RB_ENABLE) begin : g_rb_on
      assign cmd_hit = (shreg[FRAME_W-1 -: CMD_W] == RB_CODE);
   end else begin : g_rb_off
      assign cmd_hit = 1'b0;
   end

   assign cnt_full = (bit_cnt == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame   <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
         word_valid <= 1'b0;
         word_out   <= '0;
         rb_armed   <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (sel_open) begin
            in_frame <= 1'b1;
            bit_cnt  <= '0;
         end else if (sel_close) begin
            in_frame <= 1'b0;
            if (cnt_full) begin
               word_out   <= shreg;
               word_valid <= 1'b1;
               rb_armed   <= cmd_hit;
            end
         end else if (in_frame && sclk_fall && !cnt_full) begin
            shreg   <= {shreg[FRAME_W-2:0], din};
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dspi_frx_tx.sv
module dspi_frx_tx #(
   parameter int FRAME_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_frame,
   input  logic                sel_open,
   input  logic                sclk_rise,
   input  logic                shift_ok,
   input  logic                load_rb,
   input  logic [FRAME_W-1:0]  rb_word,
   input  logic [FRAME_W-1:0]  last_word,
   output logic                ser_out
);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("dspi_frx_tx: FRAME_W must be at least 2");
   end

   logic [FRAME_W-1:0] osr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr <= '0;
      end else if (sel_open) begin
         osr <= load_rb ? rb_word : last_word;
      end else if (in_frame && sclk_rise && shift_ok) begin
         osr <= {osr[FRAME_W-2:0], 1'b0};
      end
   end

   assign ser_out = osr[FRAME_W-1];

endmodule

// File: rtl/dspi_frame_rx.sv
module dspi_frame_rx
   import dspi_frx_pkg::*;
#(
   parameter int                 FRAME_W     = 24,
   parameter int                 SYNC_STAGES = 2,
   parameter int                 CMD_W       = 4,
   parameter logic [CMD_W-1:0]   RB_CODE     = 4'b1001,
   parameter bit                 RB_ENABLE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_sel_n,
   input  logic                ser_in,
   input  logic [FRAME_W-1:0]  rb_word,
   output logic                ser_out,
   output logic                ser_out_en,
   output logic                word_valid,
   output logic [FRAME_W-1:0]  word_out
);

   localparam int          CNT_W    = $clog2(FRAME_W + 1);
   localparam int          CTL_W    = 2;
   localparam int          CTL_CLK  = 1;
   localparam int          CTL_SEL  = 0;
   localparam logic [1:0]  CTL_IDLE = 2'b11;

   if (FRAME_W < CMD_W + 1) begin : g_bad_frame
      $error("dspi_frame_rx: FRAME_W too small for the command field");
   end

   edge_ev_t [CTL_W-1:0] ctl_ev;
   logic                 din_s;
   logic                 sclk_rise;
   logic                 sclk_fall;
   logic                 sel_open;
   logic                 sel_close;
   logic                 in_frame;
   logic [CNT_W-1:0]     bit_cnt;
   logic                 rb_armed;
   logic                 shift_ok;

   dspi_frx_edge #(
      .W      (CTL_W),
      .STAGES (SYNC_STAGES),
      .IDLE   (CTL_IDLE)
   ) u_ctl_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_sel_n}),
      .ev    (ctl_ev)
   );

   dspi_frx_sync #(
      .W      (1),
      .STAGES (SYNC_STAGES),
      .IDLE   (1'b0)
   ) u_din_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ser_in),
      .q     (din_s)
   );

   assign sclk_rise = ctl_ev[CTL_CLK].rise;
   assign sclk_fall = ctl_ev[CTL_CLK].fall;
   assign sel_open  = ctl_ev[CTL_SEL].fall;
   assign sel_close = ctl_ev[CTL_SEL].rise;

   dspi_frx_rx #(
      .FRAME_W   (FRAME_W),
      .CMD_W     (CMD_W),
      .RB_CODE   (RB_CODE),
      .RB_ENABLE (RB_ENABLE)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_open   (sel_open),
      .sel_close  (sel_close),
      .sclk_fall  (sclk_fall),
      .din        (din_s),
      .in_frame   (in_frame),
      .bit_cnt    (bit_cnt),
      .word_valid (word_valid),
      .word_out   (word_out),
      .rb_armed   (rb_armed)
   );

   assign shift_ok = (bit_cnt != '0);

   dspi_frx_tx #(
      .FRAME_W (FRAME_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_frame  (in_frame),
      .sel_open  (sel_open),
      .sclk_rise (sclk_rise),
      .shift_ok  (shift_ok),
      .load_rb   (rb_armed),
      .rb_word   (rb_word),
      .last_word (word_out),
      .ser_out   (ser_out)
   );

   assign ser_out_en = in_frame;

endmodule

// File: rtl/dspi_frame_rx_chk.sv
module dspi_frame_rx_chk #(
   parameter int FRAME_W = 24,
   parameter int CNT_W   = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                word_valid,
   input logic [FRAME_W-1:0]  word_out,
   input logic                ser_out,
   input logic                ser_out_en,
   input logic                sclk_rise,
   input logic [CNT_W-1:0]    bit_cnt
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   // R3: strobe lasts exactly one system clock
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R3: the captured word moves only together with the strobe
   a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (word_out != $past(word_out)) |-> word_valid);

   // R5: a strobe needs a full count of falling edges
   a_r5_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ($past(bit_cnt) == CNT_FULL));

   // R4: the bit counter never passes the frame width
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_FULL);

   // R6: no strobe while the output is being driven
   a_r6_quiet_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> !ser_out_en);

   // R7: inside a frame the output bit only moves after a serial-clock rise
   a_r7_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_out_en && $past(ser_out_en) && (ser_out != $past(ser_out)))
         |-> $past(sclk_rise));

endmodule

bind dspi_frame_rx dspi_frame_rx_chk #(
   .FRAME_W (FRAME_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_valid (word_valid),
   .word_out   (word_out),
   .ser_out    (ser_out),
   .ser_out_en (ser_out_en),
   .sclk_rise  (sclk_rise),
   .bit_cnt    (bit_cnt)
);

// File: tb/dspi_frame_rx_tb_top.sv
module dspi_frame_rx_tb_top;

   localparam int FW   = 24;
   localparam int HALF = 4;

   logic          clk       = 1'b0;
   logic          rst_n     = 1'b0;
   logic          ser_clk   = 1'b1;
   logic          ser_sel_n = 1'b1;
   logic          ser_in    = 1'b0;
   logic [FW-1:0] rb_word   = '0;
   logic          ser_out;
   logic          ser_out_en;
   logic          word_valid;
   logic [FW-1:0] word_out;

   int vectors = 0;
   int errors  = 0;
   int strobes = 0;
   bit cmp_on  = 1'b0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   dspi_frame_rx dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk    (ser_clk),
      .ser_sel_n  (ser_sel_n),
      .ser_in     (ser_in),
      .rb_word    (rb_word),
      .ser_out    (ser_out),
      .ser_out_en (ser_out_en),
      .word_valid (word_valid),
      .word_out   (word_out)
   );

   // Behavioural reference: serial history delayed by the synchronizer depth (R9)
   logic [2:0]    hc, hs, hd;
   int            m_cnt;
   logic [FW-1:0] m_isr, m_osr, m_word;
   logic          m_valid, m_oe, m_rb;
   logic          c_now, c_old, s_now, s_old, d_now;

   always @(posedge clk) begin
      if (!rst_n) begin
         hc = 3'b111; hs = 3'b111; hd = 3'b000;
         m_cnt = 0; m_isr = '0; m_osr = '0; m_word = '0;
         m_valid = 1'b0; m_oe = 1'b0; m_rb = 1'b0;
      end else begin
         c_now = hc[1]; c_old = hc[2];
         s_now = hs[1]; s_old = hs[2];
         d_now = hd[1];
         m_valid = 1'b0;
         m_oe = !s_now;
         if (!s_now && s_old) begin
            m_cnt = 0;
            m_osr = m_rb ? rb_word : m_word;
         end else if (s_now && !s_old) begin
            if (m_cnt == FW) begin
               m_word  = m_isr;
               m_valid = 1'b1;
               m_rb    = (m_isr[23:20] == 4'b1001);
            end
         end else if (!s_now) begin
            if (c_old && !c_now && m_cnt < FW) begin
               m_isr = {m_isr[FW-2:0], d_now};
               m_cnt = m_cnt + 1;
            end else if (!c_old && c_now && m_cnt > 0) begin
               m_osr = {m_osr[FW-2:0], 1'b0};
            end
         end
         hc = {hc[1:0], ser_clk};
         hs = {hs[1:0], ser_sel_n};
         hd = {hd[1:0], ser_in};
      end
   end

   task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         check("R3 word_valid vs model", FW'(word_valid), FW'(m_valid));
         check("R1 word_out vs model", word_out, m_word);
         check("R7 ser_out vs model", FW'(ser_out), FW'(m_osr[FW-1]));
         check("R6 ser_out_en vs model", FW'(ser_out_en), FW'(m_oe));
         if (word_valid) strobes++;
      end
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [31:0] bits, input int n, output logic [FW-1:0] seen);
      seen = '0;
      ser_sel_n = 1'b0;
      wait_clks(HALF);
      for (int i = n - 1; i >= 0; i--) begin
         ser_in = bits[i];
         wait_clks(HALF);
         if (n - 1 - i < FW) seen = {seen[FW-2:0], ser_out};
         ser_clk = 1'b0;
         wait_clks(HALF);
         ser_in  = ~bits[i];
         ser_clk = 1'b1;
         wait_clks(HALF);
      end
      ser_sel_n = 1'b1;
      wait_clks(2 * HALF + 2);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      logic [FW-1:0] seen;
      int s0;
      wait_clks(3);
      rst_n = 1'b1;
      wait_clks(2);
      cmp_on = 1'b1;

      // R10 reset state
      check("R10 word_out after reset", word_out, '0);
      check("R10 word_valid after reset", FW'(word_valid), '0);
      check("R10 ser_out_en after reset", FW'(ser_out_en), '0);
      check("R10 ser_out after reset", FW'(ser_out), '0);

      // R9 latency: enable appears on the third clock edge after select falls
      ser_sel_n = 1'b0;
      @(negedge clk);
      check("R9 enable after 1 edge", FW'(ser_out_en), '0);
      @(negedge clk);
      check("R9 enable after 2 edges", FW'(ser_out_en), '0);
      @(negedge clk);
      check("R9 enable after 3 edges", FW'(ser_out_en), FW'(1'b1));
      ser_sel_n = 1'b1;
      wait_clks(10);
      check("R5 empty frame gives no strobe", FW'(strobes), '0);

      // R1 R2 R3 basic frame, data flipped at every rising edge
      s0 = strobes;
      send_frame(32'h005A3C96, 24, seen);
      check("R1 R2 captured word", word_out, 24'h5A3C96);
      check("R3 one strobe per frame", FW'(strobes), FW'(s0 + 1));
      check("R7 first frame shifts reset word", seen, 24'h000000);

      // R7 daisy chain
      send_frame(32'h00E1F00D, 24, seen);
      check("R7 previous word shifted out", seen, 24'h5A3C96);
      check("R1 second word", word_out, 24'hE1F00D);

      // R4 extra falling edges ignored
      send_frame({24'h3C5AA5, 8'hF0} >> 4, 28, seen);
      check("R4 long frame keeps first 24 bits", word_out, 24'h3C5AA5);
      check("R7 chain after second frame", seen, 24'hE1F00D);

      // R5 short frame discarded
      s0 = strobes;
      send_frame(32'h000002AB, 10, seen);
      check("R5 short frame no strobe", FW'(strobes), FW'(s0));
      check("R5 short frame word unchanged", word_out, 24'h3C5AA5);

      // R8 readback request (bits 23:20 = 1001)
      send_frame(32'h00951234, 24, seen);
      check("R5 chain word skips short frame", seen, 24'h3C5AA5);
      rb_word = 24'hC0FFEE;
      send_frame(32'h00000000, 24, seen);
      check("R8 readback word shifted out", seen, 24'hC0FFEE);
      check("R8 no-op frame captured", word_out, 24'h000000);

      send_frame(32'h008F0F0F, 24, seen);
      check("R8 chain resumes after readback", seen, 24'h000000);
      send_frame(32'h00123456, 24, seen);
      check("R8 non-readback code keeps chaining", seen, 24'h8F0F0F);

      wait_clks(4);
      done = 1'b1;
      summary();
   end

endmodule